// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This block raises interrupts for one bank of general-purpose pins, made up of four ports of eight pins each. Every pad input passes through a two-stage synchronizer. Each pin then applies its own sense type to the synchronized value: rising edge, falling edge, either edge, active-high level or active-low level. Qualifying events set a sticky status bit. Each status bit is gated by its own enable bit, and a single bank interrupt is the OR of all the gated bits.

Software uses a simple synchronous register bus with a write strobe, a byte address, write data and combinational read data. Through it, software programs the per-port enable and sense-type registers, reads status, and clears status bits through a write-one-to-clear register.

The byte address is decoded as follows. Address bits [7:4] select the register: 0x4 for status (read only), 0x5 for enable, 0x6 for sense type and 0x7 for clear. Address bits [3:2] select the port.

Top module: `gpio_irq_sense`

## Requirements
- R1: While reset is held, status, enable and type registers all read 0 and `irq` is 0.
- R2: The register for port p is at byte offset 0x40 + 4p (status), 0x50 + 4p (enable), 0x60 + 4p (type) and 0x70 + 4p (clear). The clear register and any offset whose bits [7:4] are outside 4..7 read as 0. Status and enable occupy read bits [7:0].
- R3: Within a port's type register, the sense code of pin n is spread over three bits: bit n is polarity, bit n+8 selects edge (1) or level (0), and bit n+16 selects both edges. Bits [23:0] read back as written, and bits [31:24] read 0. The codes, written as {n+16, n+8, n}, are: 011 rising, 010 falling, 110 both edges, 001 level high and 000 level low.
- R4: In rising-edge mode, a 0-to-1 change of the synchronized pin sets its status bit. The bit stays set after the pin falls again, and a 1-to-0 change sets nothing.
- R5: In falling-edge mode, only a 1-to-0 change sets the status bit.
- R6: In both-edges mode, either change sets the status bit.
- R7: In level mode, status is set in every cycle that the pin is at its active level. A clear has no effect while that level persists. Once the level is gone, the bit stays set until it is cleared.
- R8: Writing 1 to bit n of a clear register clears status bit n of that port. Bits written as 0 leave status unchanged.
- R9: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when some status bit and its enable bit are both 1, across all four ports. Enable bits reset to 0.
- R11: A pad change driven just after a clock edge shows up in status after the third following rising edge, and not before.
- R12: Writes to a status offset leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 32 | Raw pad levels, port p on bits [8p+7:8p] |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Bank interrupt |

## Verification
Directed sequences program one sense type per port and drive a single pin through both transitions. This separates rising, falling and both-edge detection, and separates sticky edge status from level status that resists clearing. An event is timed into the exact cycle of a clear to expose the priority between them. Single-pin steps measure the synchronizer latency cycle by cycle. A long random phase then mixes sparse pad toggles with writes of all five sense codes, enables, clears and status writes, and compares every read and the interrupt against a cycle model in the bench.

// File: rtl/gpio_irq_sense.sv
`timescale 1ns/1ps
module gpio_irq_sense #(
  parameter int NPORT = 4,
  parameter int PW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT*PW-1:0]   pad_in,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq
);
  localparam int NPIN = NPORT * PW;
  localparam int TW   = 3 * PW;
  localparam logic [3:0] SEL_STA = 4'h4;
  localparam logic [3:0] SEL_ENA = 4'h5;
  localparam logic [3:0] SEL_TYP = 4'h6;
  localparam logic [3:0] SEL_CLR = 4'h7;

  logic [3:0]      sel;
  logic [1:0]      pidx;
  logic [NPIN-1:0] sync1, sync2, prev, sta, en;
  logic [NPIN-1:0] pol, edg, both, evt, clr, rise, fall;
  logic [TW-1:0]   typ [NPORT];
  logic [31:0]     rword [NPORT];
  logic            unused_bits;

  assign sel  = bus_addr[7:4];
  assign pidx = bus_addr[3:2];
  assign unused_bits = ^{bus_wdata[31:TW], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
      for (int p = 0; p < NPORT; p++) typ[p] <= '0;
    end else if (bus_wr) begin
      for (int p = 0; p < NPORT; p++) begin
        if (int'(pidx) == p && sel == SEL_ENA) en[p*PW +: PW] <= bus_wdata[PW-1:0];
        if (int'(pidx) == p && sel == SEL_TYP) typ[p] <= bus_wdata[TW-1:0];
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign pol[g*PW +: PW]  = typ[g][PW-1:0];
    assign edg[g*PW +: PW]  = typ[g][2*PW-1:PW];
    assign both[g*PW +: PW] = typ[g][TW-1:2*PW];
    assign clr[g*PW +: PW]  = (bus_wr && sel == SEL_CLR && int'(pidx) == g)
                              ? bus_wdata[PW-1:0] : '0;
    always_comb begin
      rword[g] = '0;
      if (int'(pidx) == g) begin
        case (sel)
          SEL_STA: rword[g][PW-1:0] = sta[g*PW +: PW];
          SEL_ENA: rword[g][PW-1:0] = en[g*PW +: PW];
          SEL_TYP: rword[g][TW-1:0] = typ[g];
          default: rword[g] = '0;
        endcase
      end
    end
  end

  assign rise = sync2 & ~prev;
  assign fall = ~sync2 & prev;
  assign evt  = (edg & ((both & (rise | fall)) |
                        (~both & pol & rise) |
                        (~both & ~pol & fall))) |
                (~edg & ~(sync2 ^ pol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sta <= '0;
    else        sta <= evt | (sta & ~clr);
  end

  assign irq = |(sta & en);

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORT; p++) bus_rdata = bus_rdata | rword[p];
  end
endmodule

module gpio_irq_sense_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] sta,
  input logic [NPIN-1:0] evt,
  input logic [NPIN-1:0] clr,
  input logic [NPIN-1:0] en,
  input logic            irq
);
  // R4
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sta & $past(evt)) == $past(evt)));
  // R9
  evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & clr)) |=> ((sta & $past(evt & clr)) == $past(evt & clr)));
  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sta & $past(clr & ~evt)) == '0));
  // R8
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sta & $past(sta & ~clr)) == $past(sta & ~clr)));
  // R12
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sta & ~$past(sta) & ~$past(evt)) == '0));
  // R10
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|en));
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NPIN(NPORT*PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sta(sta), .evt(evt), .clr(clr), .en(en), .irq(irq)
);

// File: tb/gpio_irq_sense_tb.sv
`timescale 1ns/1ps
module gpio_irq_sense_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] pad = '0;
  logic        wr = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  logic [31:0] m_s1, m_s2, m_prev, m_sta, m_en;
  logic [23:0] m_typ [4];

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] ev, cl;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_sta = '0; m_en = '0;
      for (int p = 0; p < 4; p++) m_typ[p] = '0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        logic po, ed, bo, r, f;
        po = m_typ[i/8][i%8];
        ed = m_typ[i/8][i%8 + 8];
        bo = m_typ[i/8][i%8 + 16];
        r  = m_s2[i] & ~m_prev[i];
        f  = ~m_s2[i] & m_prev[i];
        ev[i] = ed ? (bo ? (r | f) : (po ? r : f)) : (m_s2[i] == po);
      end
      cl = '0;
      if (wr && addr[7:4] == 4'h7) cl[addr[3:2]*8 +: 8] = wdata[7:0];
      m_sta  = ev | (m_sta & ~cl);
      if (wr && addr[7:4] == 4'h5) m_en[addr[3:2]*8 +: 8] = wdata[7:0];
      if (wr && addr[7:4] == 4'h6) m_typ[addr[3:2]] = wdata[23:0];
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pad;
    end
  end

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    case (a[7:4])
      4'h4: return {24'h0, m_sta[a[3:2]*8 +: 8]};
      4'h5: return {24'h0, m_en[a[3:2]*8 +: 8]};
      4'h6: return {8'h0, m_typ[a[3:2]]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [5];
    codes = '{3'b011, 3'b010, 3'b110, 3'b001, 3'b000};
    void'($urandom(32'd20240611));
    cyc(3);
    rd(8'h40, 32'h0, "R1 status in reset");
    rd(8'h54, 32'h0, "R1 enable in reset");
    rd(8'h68, 32'h0, "R1 type in reset");
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1;
    cyc(4);
    rd(8'h48, 32'hff, "R7 level low active");
    wr_reg(8'h78, 32'hff);
    rd(8'h48, 32'hff, "R7 clear ignored while low");

    wr_reg(8'h60, 32'h0000ffff);
    wr_reg(8'h70, 32'hff);
    rd(8'h40, 32'h0, "R8 clear port0");
    pad[0] = 1;
    cyc(2);
    rd(8'h40, 32'h0, "R11 not before third edge");
    cyc(1);
    rd(8'h40, 32'h1, "R11 R4 rising latched");
    pad[0] = 0;
    cyc(4);
    rd(8'h40, 32'h1, "R4 held after fall");
    wr_reg(8'h70, 32'h0);
    rd(8'h40, 32'h1, "R8 zero write no effect");
    wr_reg(8'h70, 32'h1);
    rd(8'h40, 32'h0, "R8 one clears");
    pad[0] = 1;
    cyc(2);
    wr_reg(8'h70, 32'h1);
    rd(8'h40, 32'h1, "R9 event beats clear");
    pad[0] = 0;
    cyc(4);
    wr_reg(8'h70, 32'h1);

    wr_reg(8'h64, 32'h0000ff00);
    wr_reg(8'h74, 32'hff);
    rd(8'h44, 32'h0, "R5 cleared");
    pad[8] = 1;
    cyc(4);
    rd(8'h44, 32'h0, "R5 rise ignored");
    pad[8] = 0;
    cyc(4);
    rd(8'h44, 32'h1, "R5 fall latched");

    wr_reg(8'h68, 32'h00ffff00);
    wr_reg(8'h78, 32'hff);
    rd(8'h48, 32'h0, "R6 cleared");
    pad[16] = 1;
    cyc(4);
    rd(8'h48, 32'h1, "R6 rise latched");
    wr_reg(8'h78, 32'h1);
    pad[16] = 0;
    cyc(4);
    rd(8'h48, 32'h1, "R6 fall latched");

    wr_reg(8'h6c, 32'h000000ff);
    wr_reg(8'h7c, 32'hff);
    rd(8'h4c, 32'h0, "R7 high inactive");
    pad[24] = 1;
    cyc(4);
    rd(8'h4c, 32'h1, "R7 level high set");
    wr_reg(8'h7c, 32'h1);
    rd(8'h4c, 32'h1, "R7 clear ignored while high");
    pad[24] = 0;
    cyc(4);
    rd(8'h4c, 32'h1, "R7 stays until cleared");
    wr_reg(8'h7c, 32'h1);
    rd(8'h4c, 32'h0, "R7 clear after level gone");

    chk("R10 irq enables zero", {31'h0, irq}, 32'h0);
    wr_reg(8'h5c, 32'h1);
    chk("R10 irq no status", {31'h0, irq}, 32'h0);
    pad[24] = 1;
    cyc(4);
    chk("R10 irq raised", {31'h0, irq}, 32'h1);
    wr_reg(8'h5c, 32'h0);
    chk("R10 irq masked", {31'h0, irq}, 32'h0);
    wr_reg(8'h5c, 32'h1);
    chk("R10 irq unmasked", {31'h0, irq}, 32'h1);
    pad[24] = 0;
    cyc(4);
    wr_reg(8'h7c, 32'h1);
    chk("R10 irq after clear", {31'h0, irq}, 32'h0);
    rd(8'h5c, 32'h1, "R2 enable readback");

    wr_reg(8'h48, 32'h0);
    rd(8'h48, 32'h1, "R12 status write ignored");
    wr_reg(8'h40, 32'hff);
    rd(8'h40, 32'h0, "R12 status write ignored");
    wr_reg(8'h60, 32'hffffffff);
    rd(8'h60, 32'h00ffffff, "R3 type readback");
    rd(8'h30, 32'h0, "R2 unmapped low");
    rd(8'h80, 32'h0, "R2 unmapped high");
    rd(8'h74, 32'h0, "R2 clear reads zero");

    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [1:0] p;
      if ($urandom % 8 == 0) pad = pad ^ (32'h1 << ($urandom % 32));
      r = $urandom % 10;
      p = 2'($urandom % 4);
      wr = 0;
      wdata = $urandom;
      if (r < 2) begin
        for (int b = 0; b < 8; b++) begin
          logic [2:0] c;
          c = codes[$urandom % 5];
          wdata[b] = c[0]; wdata[b+8] = c[1]; wdata[b+16] = c[2];
        end
        wr = 1; addr = {4'h6, p, 2'b00};
      end else if (r < 4) begin
        wr = 1; addr = {4'h5, p, 2'b00};
      end else if (r < 6) begin
        wr = 1; addr = {4'h7, p, 2'b00};
      end else if (r == 6) begin
        wr = 1; addr = {4'h4, p, 2'b00};
      end else begin
        addr = {2'b01, 2'($urandom % 4), p, 2'b00};
      end
      #1;
      case (addr[7:4])
        4'h4: chk("R4 random status", rdata, model_rd(addr));
        4'h5: chk("R10 random enable", rdata, model_rd(addr));
        4'h6: chk("R3 random type", rdata, model_rd(addr));
        default: chk("R2 random clear", rdata, model_rd(addr));
      endcase
      chk("R10 random irq", {31'h0, irq}, {31'h0, |(m_sta & m_en)});
      @(negedge clk);
    end
    wr = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule